// File: doc/BRIEF.md
# Shift-Left Flag Unit

This block is a 16-bit logical left-shift execution unit for a small coprocessor datapath. It takes a destination operand, an amount source and a mode select, and returns the shifted value together with updated negative, zero, overflow and carry condition flags. The amount comes either from a 4-bit immediate field or from the full 16-bit value of a source register. Both sources are decoded with saturation rules so that the effective amount always lies between 0 and 16.

The unit samples its inputs on a clock edge where `in_valid` is high. One cycle later it presents the registered result and flags with `out_valid`. The current carry flag is an input, so a zero-length shift can pass it through untouched. Instruction fetch, opcode decoding, the register file and the other ALU operations live elsewhere.

Top module: `shl_flag_unit`

## Requirements
- R1: Inputs are captured on a rising clock edge with `in_valid` high. `out_valid` is high in the following cycle only. While `in_valid` is low, the result and flags hold their last values.
- R2: The result is the operand shifted left by the effective amount n, with the low n bits filled with zeros. For n = 16 the result is 0x0000.
- R3: When `mode_reg` = 0 (immediate mode), n equals `imm_amt`, except that `imm_amt` = 0 gives n = 16.
- R4: When `mode_reg` = 1 (register mode), n equals `src_amt` for values 0 to 15. Any `src_amt` above 15 gives n = 16.
- R5: For n > 0, `flag_c` is bit (16 - n) of the operand before the shift. For n = 16 this is bit 0.
- R6: For n = 0, `flag_c` equals `carry_in` and the result equals the operand.
- R7: `flag_n` equals bit 15 of the result.
- R8: `flag_z` is 1 exactly when the result is 0x0000.
- R9: `flag_v` is the XOR of operand bit 15 and result bit 15.
- R10: A synchronous active-high `rst` clears `out_valid`, the result and all four flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs are sampled on this cycle |
| mode_reg | input | 1 | 0 = immediate amount, 1 = register amount |
| imm_amt | input | 4 | Immediate amount field (0 means 16) |
| src_amt | input | 16 | Register amount value (above 15 means 16) |
| operand | input | 16 | Value to shift |
| carry_in | input | 1 | Present carry flag, passed through for n = 0 |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 16 | Shifted value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest case to reach is a carry that must survive a shift. This happens only in register mode with a source of exactly zero, and it is visible only when `carry_in` differs from the carry that a real shift would have produced. The bench runs every register amount from 0 to 20 and 0xFFFF with both carry inputs and random operands. It also sweeps every immediate value, so the zero-length pass-through, the immediate-zero-means-sixteen rule and register saturation each appear with carry_in at 0 and at 1. Operands 0x8000, 0x4000 and 0x0000 make the overflow and zero flags take both values.

// File: rtl/shl_pkg.sv
package shl_pkg;

  typedef enum logic {
    SHL_MODE_IMM = 1'b0,
    SHL_MODE_REG = 1'b1
  } shl_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } shl_flags_t;

endpackage

// File: rtl/shl_amt_decode.sv
module shl_amt_decode
  import shl_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 4,
  parameter int SRC_W = 16,
  parameter int AMT_W = 5
) (
  input  shl_mode_e          mode,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SRC_W-1:0]   src,
  output logic [AMT_W-1:0]   amt,
  output logic               amt_zero,
  output logic               amt_full
);

  function automatic logic [AMT_W-1:0] decode_imm(input logic [IMM_W-1:0] v);
    if (v == '0) return AMT_W'(WIDTH);
    return AMT_W'(v);
  endfunction

  function automatic logic [AMT_W-1:0] decode_src(input logic [SRC_W-1:0] v);
    if (v >= SRC_W'(WIDTH)) return AMT_W'(WIDTH);
    return AMT_W'(v);
  endfunction

  always_comb begin
    if (mode == SHL_MODE_REG) amt = decode_src(src);
    else                      amt = decode_imm(imm);
    amt_zero = (amt == '0);
    amt_full = (amt == AMT_W'(WIDTH));
  end

endmodule

// File: rtl/shl_barrel.sv
module shl_barrel #(
  parameter int WIDTH = 16,
  parameter int AMT_W = 5
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] amt,
  input  logic             amt_zero,
  input  logic             carry_in,
  output logic [WIDTH-1:0] data_out,
  output logic             carry_out
);

  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] stage [AMT_W+1];

  assign stage[0] = {1'b0, data_in};

  generate
    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
      assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
    end
  endgenerate

  assign data_out  = stage[AMT_W][WIDTH-1:0];
  assign carry_out = amt_zero ? carry_in : stage[AMT_W][WIDTH];

endmodule

// File: rtl/shl_flag_gen.sv
module shl_flag_gen
  import shl_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             src_msb,
  input  logic [WIDTH-1:0] res,
  input  logic             carry,
  output shl_flags_t       flags
);

  function automatic shl_flags_t make_flags(input logic msb_before,
                                            input logic [WIDTH-1:0] value,
                                            input logic c);
    shl_flags_t f;
    f.n = value[WIDTH-1];
    f.z = (value == '0);
    f.v = msb_before ^ value[WIDTH-1];
    f.c = c;
    return f;
  endfunction

  assign flags = make_flags(src_msb, res, carry);

endmodule

// File: rtl/shl_flag_unit.sv
module shl_flag_unit
  import shl_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 4,
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             mode_reg,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [SRC_W-1:0] src_amt,
  input  logic [WIDTH-1:0] operand,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);

  localparam int AMT_W = $clog2(WIDTH + 1);

  shl_mode_e        mode;
  logic [AMT_W-1:0] amt_dec;
  logic             amt_zero;
  logic             amt_full;
  logic [WIDTH-1:0] shifted;
  logic             shift_carry;
  shl_flags_t       next_flags;

  assign mode = shl_mode_e'(mode_reg);

  shl_amt_decode #(
    .WIDTH(WIDTH), .IMM_W(IMM_W), .SRC_W(SRC_W), .AMT_W(AMT_W)
  ) u_dec (
    .mode     (mode),
    .imm      (imm_amt),
    .src      (src_amt),
    .amt      (amt_dec),
    .amt_zero (amt_zero),
    .amt_full (amt_full)
  );

  shl_barrel #(
    .WIDTH(WIDTH), .AMT_W(AMT_W)
  ) u_shift (
    .data_in   (operand),
    .amt       (amt_dec),
    .amt_zero  (amt_zero),
    .carry_in  (carry_in),
    .data_out  (shifted),
    .carry_out (shift_carry)
  );

  shl_flag_gen #(
    .WIDTH(WIDTH)
  ) u_flags (
    .src_msb (operand[WIDTH-1]),
    .res     (shifted),
    .carry   (shift_carry),
    .flags   (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= shifted;
        flag_n <= next_flags.n;
        flag_z <= next_flags.z;
        flag_v <= next_flags.v;
        flag_c <= next_flags.c;
      end
    end
  end

endmodule

// File: rtl/shl_flag_unit_chk.sv
module shl_flag_unit_chk #(
  parameter int WIDTH = 16,
  parameter int IMM_W = 4,
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             mode_reg,
  input logic [IMM_W-1:0] imm_amt,
  input logic [SRC_W-1:0] src_amt,
  input logic [WIDTH-1:0] operand,
  input logic             carry_in,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c,
  input logic             amt_zero,
  input logic             amt_full
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_v)));

  // R3
  imm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_reg && imm_amt == '0) |=>
      (result == '0 && flag_c == $past(operand[0])));

  // R4
  reg_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_reg && src_amt >= SRC_W'(WIDTH)) |=>
      (result == '0 && flag_c == $past(operand[0])));

  // R6
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_reg && src_amt == '0) |=>
      (flag_c == $past(carry_in) && result == $past(operand)));

  // R6
  zero_only_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt_zero) |-> mode_reg);

  // R2
  full_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt_full) |=> (result == '0 && flag_z));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_z == (result == '0)));

  // R7
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_n == result[WIDTH-1]));

  // R9
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_v == ($past(operand[WIDTH-1]) ^ result[WIDTH-1])));

endmodule

bind shl_flag_unit shl_flag_unit_chk #(
  .WIDTH(WIDTH), .IMM_W(IMM_W), .SRC_W(SRC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode_reg  (mode_reg),
  .imm_amt   (imm_amt),
  .src_amt   (src_amt),
  .operand   (operand),
  .carry_in  (carry_in),
  .out_valid (out_valid),
  .result    (result),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c),
  .amt_zero  (amt_zero),
  .amt_full  (amt_full)
);

// File: tb/tb_shl_flag_unit.sv
`timescale 1ns/1ps
module tb_shl_flag_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        mode_reg;
  logic [3:0]  imm_amt;
  logic [15:0] src_amt;
  logic [15:0] operand;
  logic        carry_in;
  logic        out_valid;
  logic [15:0] result;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shl_flag_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_reg(mode_reg),
    .imm_amt(imm_amt), .src_amt(src_amt), .operand(operand),
    .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bit-serial reference: one position per step, carry is the bit pushed out.
  task automatic ref_model(input logic m, input logic [3:0] im,
                           input logic [15:0] sa, input logic [15:0] op,
                           input logic ci, output logic [15:0] r,
                           output logic c, output int n);
    if (m) n = (sa > 16'd15) ? 16 : int'(sa);
    else   n = (im == 4'd0) ? 16 : int'(im);
    r = op;
    c = ci;
    for (int k = 0; k < n; k++) begin
      c = r[15];
      r = {r[14:0], 1'b0};
    end
  endtask

  task automatic run_op(input logic m, input logic [3:0] im,
                        input logic [15:0] sa, input logic [15:0] op,
                        input logic ci, input string mtag);
    logic [15:0] er;
    logic        ec;
    int          n;
    ref_model(m, im, sa, op, ci, er, ec, n);
    @(negedge clk);
    in_valid = 1'b1; mode_reg = m; imm_amt = im; src_amt = sa;
    operand = op; carry_in = ci;
    @(negedge clk);
    in_valid = 1'b0;
    operand = ~op; src_amt = 16'h0001; imm_amt = 4'd1; carry_in = ~ci;
    check("R1", "out_valid", {15'd0, out_valid}, 16'd1);
    check(mtag, "result", result, er);
    check("R2", "zero fill", result & ((16'h1 << n) - 16'h1), 16'h0);
    check((n == 0) ? "R6" : "R5", "flag_c", {15'd0, flag_c}, {15'd0, ec});
    check("R7", "flag_n", {15'd0, flag_n}, {15'd0, er[15]});
    check("R8", "flag_z", {15'd0, flag_z}, {15'd0, (er == 16'h0)});
    check("R9", "flag_v", {15'd0, flag_v}, {15'd0, op[15] ^ er[15]});
  endtask

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b0; mode_reg = 1'b0; imm_amt = '0;
    src_amt = '0; operand = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "out_valid", {15'd0, out_valid}, 16'd0);
    check("R10", "result", result, 16'h0);
    check("R10", "flags", {12'd0, flag_n, flag_z, flag_v, flag_c}, 16'h0);
    rst = 1'b0;
  endtask

  task automatic test_reg_amounts();
    for (int a = 0; a <= 21; a++) begin
      for (int ci = 0; ci < 2; ci++) begin
        logic [15:0] sa;
        sa = (a == 21) ? 16'hFFFF : 16'(a);
        run_op(1'b1, 4'($urandom), sa, 16'($urandom), ci[0], "R4");
      end
    end
  endtask

  task automatic test_imm_all();
    for (int im = 0; im < 16; im++) begin
      for (int ci = 0; ci < 2; ci++) begin
        run_op(1'b0, 4'(im), 16'($urandom), 16'($urandom), ci[0], "R3");
      end
    end
  endtask

  task automatic test_flag_edges();
    run_op(1'b0, 4'd1, 16'h0, 16'h8000, 1'b0, "R9");
    run_op(1'b0, 4'd1, 16'h0, 16'h4000, 1'b0, "R9");
    run_op(1'b1, 4'd0, 16'd5, 16'h0000, 1'b1, "R8");
    run_op(1'b1, 4'd0, 16'd0, 16'hFFFF, 1'b0, "R6");
    run_op(1'b1, 4'd0, 16'd16, 16'h0001, 1'b0, "R4");
  endtask

  task automatic test_hold();
    logic [15:0] held;
    logic        hc;
    run_op(1'b1, 4'd0, 16'd3, 16'h1234, 1'b0, "R2");
    held = result;
    hc = flag_c;
    operand = 16'hFFFF; src_amt = 16'd1; mode_reg = 1'b1; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "out_valid idle", {15'd0, out_valid}, 16'd0);
    check("R1", "result held", result, held);
    check("R1", "carry held", {15'd0, flag_c}, {15'd0, hc});
  endtask

  task automatic test_reset_mid();
    run_op(1'b1, 4'd0, 16'd0, 16'hFFFF, 1'b1, "R6");
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R10", "out_valid", {15'd0, out_valid}, 16'd0);
    check("R10", "result", result, 16'h0);
    check("R10", "flags", {12'd0, flag_n, flag_z, flag_v, flag_c}, 16'h0);
  endtask

  initial begin
    test_reset();
    test_reg_amounts();
    test_imm_all();
    test_flag_edges();
    test_hold();
    test_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule